// File: doc/BRIEF.md
# Quarter-Rate Quadrature-to-Real Upconverter

This block turns a stream of complex samples (signed in-phase and quadrature words) into one stream of real samples. The output spectrum is shifted by one quarter of the sample rate. At that shift the local oscillator only takes the values 0, +1 and −1. The mixing therefore needs no multipliers: a two-bit phase counter picks one lane per sample, and that lane is either passed through or negated.

A direction bit selects an upward shift, so the input spectrum fills the upper sideband of the real output, or a downward shift, which fills the lower sideband. A sync input forces the oscillator to zero degrees on the sample that comes with it. A two-bit gain mode selects unity gain or a gain of two. Negation and doubling saturate to the signed output range instead of wrapping. Input and output are qualified by valid strobes, and the output is registered with a fixed latency of one cycle.

Top module: `qrt_upconv`

## Requirements
- R1: With `shift_up` high, phases 0, 1, 2 and 3 produce i, −q, −i and q in that order.
- R2: With `shift_up` low, phases 0, 1, 2 and 3 produce i, q, −i and −q in that order.
- R3: The phase advances by one (modulo 4) for each sample accepted with `in_valid` high, and holds while `in_valid` is low.
- R4: A sample with `sync` high is mixed at phase 0, and the next accepted sample is mixed at phase 1.
- R5: With `gain_mode` = 2'b00, the mixed value goes out unscaled.
- R6: With `gain_mode` set to 2'b01, 2'b10 or 2'b11, the mixed value is doubled and saturates to the range [−2^(W−1), 2^(W−1)−1].
- R7: Negating the most negative input value gives the most positive output value.
- R8: `out_valid` equals `in_valid` delayed by exactly one clock.
- R9: `out_data` holds its value in any cycle that follows a cycle with `in_valid` low.
- R10: A synchronous reset clears `out_valid` and `out_data` to 0 and returns the phase to 0, so the first sample after reset is mixed at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | W | In-phase sample, signed |
| in_q | input | W | Quadrature sample, signed |
| sync | input | 1 | Forces phase 0 on this sample |
| shift_up | input | 1 | 1 = upward shift, 0 = downward shift |
| gain_mode | input | 2 | 00 = unity gain, any other value = gain of two |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | W | Real output sample, signed |

## Verification
The bench steps through all four phases in both shift directions. A design with the wrong sign on one lane, or with the lane orders swapped, gives the wrong sign at phases 1 and 3. It drives the most negative input into a negation and large values into the doubler. A design that wraps instead of saturating flips the sign of those results. A gap in `in_valid` and a sync in the middle of the stream are also applied: a counter that runs freely, or a sync that takes effect one sample late, moves every later output to the wrong lane. A reset in the middle of the stream checks that the phase returns to 0.

// File: rtl/qrt_pkg.sv
package qrt_pkg;
  typedef enum logic [1:0] {PH_0 = 2'd0, PH_90 = 2'd1, PH_180 = 2'd2, PH_270 = 2'd3} phase_t;
  localparam logic [1:0] GAIN_UNITY = 2'b00;
endpackage

// File: rtl/qrt_phase_ctr.sv
module qrt_phase_ctr
  import qrt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   adv,
  input  logic   sync,
  output phase_t cur
);
  logic [1:0] cnt_q;

  assign cur = sync ? PH_0 : phase_t'(cnt_q);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= 2'd0;
    else if (adv) cnt_q <= 2'(cur) + 2'd1;
  end

  // R3: the phase holds while no sample is accepted
  p_hold_phase_r3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt_q));
  // R4: after a synced sample the next phase is 90 degrees
  p_sync_next_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && sync) |=> (cnt_q == 2'd1));
endmodule

// File: rtl/qrt_lane_mux.sv
module qrt_lane_mux
  import qrt_pkg::*;
#(
  parameter int W = 16
) (
  input  phase_t        ph,
  input  logic          up,
  input  logic [W-1:0]  i_s,
  input  logic [W-1:0]  q_s,
  output logic [W-1:0]  mixed
);
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] neg_i, neg_q;

  // saturating negation: the most negative value maps to the most positive
  assign neg_i = (i_s == MIN_V) ? MAX_V : (~i_s + 1'b1);
  assign neg_q = (q_s == MIN_V) ? MAX_V : (~q_s + 1'b1);

  always_comb begin
    unique case (ph)
      PH_0:    mixed = i_s;
      PH_90:   mixed = up ? neg_q : q_s;
      PH_180:  mixed = neg_i;
      PH_270:  mixed = up ? q_s : neg_q;
      default: mixed = i_s;
    endcase
  end
endmodule

// File: rtl/qrt_gain.sv
module qrt_gain #(
  parameter int W = 16
) (
  input  logic         dbl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

  logic ovf;
  assign ovf = din[W-1] ^ din[W-2];

  always_comb begin
    if (!dbl)     dout = din;
    else if (ovf) dout = din[W-1] ? MIN_V : MAX_V;
    else          dout = {din[W-2:0], 1'b0};
  end
endmodule

// File: rtl/qrt_upconv.sv
module qrt_upconv
  import qrt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  input  logic         sync,
  input  logic         shift_up,
  input  logic [1:0]   gain_mode,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  phase_t       ph;
  logic [W-1:0] mixed, scaled;
  logic         dbl;

  assign dbl = (gain_mode != GAIN_UNITY);

  qrt_phase_ctr u_phase (
    .clk (clk), .rst (rst), .adv (in_valid), .sync (sync), .cur (ph)
  );

  qrt_lane_mux #(.W(W)) u_mux (
    .ph (ph), .up (shift_up), .i_s (in_i), .q_s (in_q), .mixed (mixed)
  );

  qrt_gain #(.W(W)) u_gain (
    .dbl (dbl), .din (mixed), .dout (scaled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= scaled;
    end
  end

  // R8: one-cycle valid latency
  p_valid_lat_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_lat_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9: data holds after an idle cycle
  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  // R5: a synced sample at unity gain passes the in-phase lane unchanged
  p_sync_unity_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sync && gain_mode == GAIN_UNITY) |=> (out_data == $past(in_i)));
  // R6: doubling never wraps a positive value to a non-positive one
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sync && gain_mode != GAIN_UNITY && $signed(in_i) > 0)
      |=> ($signed(out_data) > 0));
endmodule

// File: tb/qrt_upconv_bench.sv
module qrt_upconv_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, sync, shift_up;
  logic [W-1:0] in_i, in_q;
  logic [1:0]   gain_mode;
  logic         out_valid;
  logic [W-1:0] out_data;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  qrt_upconv #(.W(W)) u_qrt_upconv (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_i (in_i), .in_q (in_q),
    .sync (sync), .shift_up (shift_up), .gain_mode (gain_mode),
    .out_valid (out_valid), .out_data (out_data)
  );

  // entry: {valid, sync, up, mode[1:0], i, q, expected}
  localparam int N = 18;
  localparam logic [52:0] TBL [N] = '{
    {1'b1,1'b1,1'b1,2'd0, 16'sd100,   16'sd7,     16'sd100},    // R1 ph0, R4
    {1'b1,1'b0,1'b1,2'd0, 16'sd5,     16'sd20,   -16'sd20},     // R1 ph1
    {1'b1,1'b0,1'b1,2'd0, 16'sd30,    16'sd1,    -16'sd30},     // R1 ph2
    {1'b1,1'b0,1'b1,2'd0, 16'sd2,     16'sd40,    16'sd40},     // R1 ph3
    {1'b1,1'b0,1'b0,2'd0, 16'sd11,    16'sd3,     16'sd11},     // R2 ph0
    {1'b1,1'b0,1'b0,2'd0, 16'sd4,     16'sd9,     16'sd9},      // R2 ph1
    {1'b1,1'b0,1'b0,2'd0, 16'sd6,     16'sd2,    -16'sd6},      // R2 ph2
    {1'b1,1'b0,1'b0,2'd0, 16'sd1,     16'sd8,    -16'sd8},      // R2 ph3
    {1'b1,1'b0,1'b1,2'd1, 16'sd50,    16'sd0,     16'sd100},    // R6 mode01
    {1'b1,1'b0,1'b1,2'd2, 16'sd0,     16'sd25,   -16'sd50},     // R6 mode10
    {1'b1,1'b0,1'b1,2'd3, 16'sd20000, 16'sd0,    -16'sd32768},  // R6 sat low
    {1'b1,1'b0,1'b1,2'd3, 16'sd0,     16'sd20000, 16'sd32767},  // R6 sat high
    {1'b1,1'b1,1'b1,2'd0,-16'sd32768, 16'sd0,    -16'sd32768},  // R5 min passes
    {1'b1,1'b0,1'b1,2'd0, 16'sd0,    -16'sd32768, 16'sd32767},  // R7 -q
    {1'b0,1'b0,1'b1,2'd0, 16'sd999,   16'sd999,   16'sd32767},  // R9 hold, R3
    {1'b1,1'b0,1'b1,2'd0,-16'sd32768, 16'sd3,     16'sd32767},  // R7 -i, R3 ph2
    {1'b1,1'b1,1'b1,2'd0, 16'sd7,     16'sd9,     16'sd7},      // R4 mid-stream
    {1'b1,1'b0,1'b1,2'd0, 16'sd1,    -16'sd5,     16'sd5}       // R4 next ph1
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic up, input logic [1:0] m,
                       input logic [W-1:0] i, input logic [W-1:0] q);
    in_valid = v; sync = s; shift_up = up; gain_mode = m; in_i = i; in_q = q;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 2'd0, '0, '0);
    repeat (3) @(negedge clk);
    check("R10 valid", {15'd0, out_valid}, 16'd0);
    check("R10 data", out_data, 16'd0);
    rst = 1'b0;

    // R10: first sample after reset, no sync, must use phase 0
    drive(1'b1, 1'b0, 1'b1, 2'd0, 16'sd3, 16'sd4);
    @(negedge clk);
    check("R10 phase0", out_data, 16'sd3);
    check("R8 valid", {15'd0, out_valid}, 16'd1);

    for (int k = 0; k < N; k++) begin
      drive(TBL[k][52], TBL[k][51], TBL[k][50], TBL[k][49:48], TBL[k][47:32], TBL[k][31:16]);
      @(negedge clk);
      check($sformatf("R1-table %0d", k), out_data, TBL[k][15:0]);
      check("R8 valid follows", {15'd0, out_valid}, {15'd0, TBL[k][52]});
    end

    // R10: reset in the middle of the stream returns the phase to 0
    drive(1'b1, 1'b0, 1'b1, 2'd0, 16'sd1, 16'sd1);
    @(negedge clk);                      // phase 2 consumed, counter now 3
    rst = 1'b1; drive(1'b0, 1'b0, 1'b1, 2'd0, '0, '0);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 1'b0, 1'b1, 2'd0, 16'sd21, 16'sd22);
    @(negedge clk);
    check("R10 mid reset", out_data, 16'sd21);

    // R3: two idle cycles, then the next sample is at phase 1 (up: -q)
    drive(1'b0, 1'b0, 1'b1, 2'd0, 16'sd5, 16'sd5);
    repeat (2) @(negedge clk);
    check("R9 idle hold", out_data, 16'sd21);
    drive(1'b1, 1'b0, 1'b1, 2'd0, 16'sd8, 16'sd13);
    @(negedge clk);
    check("R3 after gap", out_data, -16'sd13);
    drive(1'b0, 1'b0, 1'b1, 2'd0, '0, '0);
    @(negedge clk);
    check("R8 idle", {15'd0, out_valid}, 16'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule